// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits on the read path of a byte-wide flash array model. While the model runs an internal program or erase, the block replaces the array byte with a status byte. The status byte reports progress through a polarity bit, a timeout bit, an erase-phase bit and two toggle bits. When no operation is running, and for reads outside the suspended sector during erase suspend, the array byte goes through unchanged.

The command decoder supplies the current operating mode, the byte last written, the erase-marked sector set and the timeout flag. The read path supplies the address, the array byte and a read strobe. Each rising edge of the strobe is one read access. On that edge the block takes one sample and registers it onto the output. The output then holds until the next rising edge.

Top module: `flash_status_gen`

## Requirements
- R1: After synchronous reset the output byte is 0x00 and both toggle states are 0. The first read that advances a toggle state therefore returns 1 in that bit.
- R2: Mode codes are: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during suspend. Codes 5 to 7 act as idle. In idle, a read returns the array byte unchanged, whatever the timeout input.
- R3: In program (1) and program during suspend (4), bit 7 of a read is the complement of bit 7 of the last written byte, and bit 3 is 0.
- R4: In erase (2), bit 7 of a read is 0 and bit 3 is 1.
- R5: In modes 1, 2 and 4, bit 6 inverts on every read, at any address.
- R6: The sector number is the top 5 address bits, and a sector is marked when its bit in the sector mask is set. Bit 2 inverts on each read of a marked sector in modes 2, 3 and 4. On any other read in modes 1, 2 and 4, bit 2 reads 1 and its toggle state does not advance.
- R7: In erase suspended (3), a read of a marked sector returns bit 7 = 1, bit 6 = 1, bit 5 = 0 and bit 3 = 0. A read of an unmarked sector returns the array byte, and neither toggle state advances.
- R8: In modes 1, 2 and 4, bit 5 equals the timeout input, and the other status bits keep the values they have without a timeout.
- R9: Bits 4, 1 and 0 are 0 whenever a status byte is output.
- R10: The output changes only on a rising edge of the read strobe. Holding the strobe high counts as one read. Input changes between reads leave the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode code |
| last_data | input | 8 | Byte last written by a program command |
| rd_addr | input | ADDR_W | Read address |
| erase_mask | input | NUM_SECT | One bit per sector marked for erase |
| timeout | input | 1 | Operation exceeded its time limit |
| rd_stb | input | 1 | Read strobe; each rising edge is one read |
| array_data | input | 8 | Byte read from the array |
| dq | output | 8 | Registered read result |

## Verification
The bench walks the modes in a sequence chosen so that toggle state carries across mode changes. A design that advanced bit 2 on an unmarked read, or on a passthrough read during suspend, returns the wrong phase on the next marked read. It reads with the timeout set and cleared in every mode where timeout matters. This catches a design that lets timeout corrupt bit 7 or leak into the suspend status. It also holds the strobe high over several cycles and changes inputs between reads. A level-sensitive or free-running design would then advance bit 6 more than once, or change the held output.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_PROG  = 3'd1,
    M_ERASE = 3'd2,
    M_ESUSP = 3'd3,
    M_SPROG = 3'd4
  } fsg_mode_e;
endpackage

// File: rtl/fsg_toggle_bit.sv
module fsg_toggle_bit (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else if (adv) q <= ~q;
  end

  // R5 R6: one inversion per advancing read, otherwise held
  a_r5_flip_on_adv: assert property (@(posedge clk) disable iff (rst)
    adv |=> q != $past(q));
  a_r6_hold_no_adv: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(q));
endmodule

// File: rtl/fsg_sector_hit.sv
module fsg_sector_hit #(
  parameter int ADDR_W   = 21,
  parameter int NUM_SECT = 32
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_SECT-1:0] mask,
  output logic                hit
);
  localparam int SECT_W = $clog2(NUM_SECT);
  logic [SECT_W-1:0] sect;

  assign sect = addr[ADDR_W-1 -: SECT_W];
  assign hit  = mask[sect];
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int NUM_SECT = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          mode,
  input  logic [7:0]          last_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_SECT-1:0] erase_mask,
  input  logic                timeout,
  input  logic                rd_stb,
  input  logic [7:0]          array_data,
  output logic [7:0]          dq
);
  fsg_mode_e md;
  logic stb_q, rise, hit;
  logic adv6, adv2, t6, t2, t6n, t2n;
  logic use_stat;
  logic [7:0] stat, dq_nxt;

  assign md   = fsg_mode_e'(mode);
  assign rise = rd_stb & ~stb_q;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= rd_stb;
  end

  fsg_sector_hit #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) u_hit (
    .addr(rd_addr), .mask(erase_mask), .hit(hit)
  );

  always_comb begin
    adv6 = rise && (md == M_PROG || md == M_ERASE || md == M_SPROG);
    adv2 = rise && hit && (md == M_ERASE || md == M_ESUSP || md == M_SPROG);
  end

  fsg_toggle_bit u_tog6 (.clk(clk), .rst(rst), .adv(adv6), .q(t6));
  fsg_toggle_bit u_tog2 (.clk(clk), .rst(rst), .adv(adv2), .q(t2));

  assign t6n = t6 ^ adv6;
  assign t2n = t2 ^ adv2;

  always_comb begin
    stat     = 8'h00;
    use_stat = 1'b0;
    case (md)
      M_PROG, M_SPROG: begin
        use_stat = 1'b1;
        stat[7]  = ~last_data[7];
        stat[6]  = t6n;
        stat[5]  = timeout;
        stat[2]  = (md == M_SPROG && hit) ? t2n : 1'b1;
      end
      M_ERASE: begin
        use_stat = 1'b1;
        stat[7]  = 1'b0;
        stat[6]  = t6n;
        stat[5]  = timeout;
        stat[3]  = 1'b1;
        stat[2]  = hit ? t2n : 1'b1;
      end
      M_ESUSP: begin
        use_stat = hit;
        stat[7]  = 1'b1;
        stat[6]  = 1'b1;
        stat[2]  = t2n;
      end
      default: use_stat = 1'b0;
    endcase
    dq_nxt = use_stat ? stat : array_data;
  end

  always_ff @(posedge clk) begin
    if (rst) dq <= 8'h00;
    else if (rise) dq <= dq_nxt;
  end

  // R2: idle read passes the array byte
  a_r2_idle_pass: assert property (@(posedge clk) disable iff (rst)
    (rise && md == M_IDLE) |=> dq == $past(array_data));
  // R3: program polarity bit
  a_r3_prog_dq7: assert property (@(posedge clk) disable iff (rst)
    (rise && (md == M_PROG || md == M_SPROG)) |=> dq[7] == ~$past(last_data[7]));
  // R4: erase pattern
  a_r4_erase_bits: assert property (@(posedge clk) disable iff (rst)
    (rise && md == M_ERASE) |=> (dq[7] == 1'b0 && dq[3] == 1'b1));
  // R8: timeout bit follows the input while an operation runs
  a_r8_timeout: assert property (@(posedge clk) disable iff (rst)
    (rise && (md == M_PROG || md == M_ERASE || md == M_SPROG)) |=> dq[5] == $past(timeout));
  // R9: undefined status bits are zero
  a_r9_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (rise && (md == M_PROG || md == M_ERASE || md == M_SPROG)) |=> (dq[4] | dq[1] | dq[0]) == 1'b0);
  // R10: output only moves on a strobe rising edge
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(dq));
endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  last_data = 8'h00;
  logic [20:0] rd_addr = '0;
  logic [31:0] erase_mask = '0;
  logic        timeout = 1'b0;
  logic        rd_stb = 1'b0;
  logic [7:0]  array_data = 8'h00;
  logic [7:0]  dq;

  int checks = 0;
  int fails  = 0;
  logic m6 = 1'b0, m2 = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       smp;

  always #10 clk = ~clk;

  flash_status_gen u_dut (
    .clk(clk), .rst(rst), .mode(mode), .last_data(last_data), .rd_addr(rd_addr),
    .erase_mask(erase_mask), .timeout(timeout), .rd_stb(rd_stb),
    .array_data(array_data), .dq(dq)
  );

  function automatic logic [20:0] sa(input int s);
    return {s[4:0], 16'h1234};
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: dq=%02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [2:0] m, input logic [7:0] ld,
                                       input logic [20:0] a, input logic [31:0] msk,
                                       input logic to, input logic [7:0] arr);
    logic hit;
    logic [7:0] e;
    hit = msk[a[20:16]];
    e = 8'h00;
    case (m)
      3'd1, 3'd4: begin
        m6 = ~m6;
        e[7] = ~ld[7]; e[6] = m6; e[5] = to;
        if (m == 3'd4 && hit) begin m2 = ~m2; e[2] = m2; end
        else e[2] = 1'b1;
      end
      3'd2: begin
        m6 = ~m6;
        e[7] = 1'b0; e[6] = m6; e[5] = to; e[3] = 1'b1;
        if (hit) begin m2 = ~m2; e[2] = m2; end
        else e[2] = 1'b1;
      end
      3'd3: begin
        if (hit) begin m2 = ~m2; e = {1'b1, 1'b1, 3'b000, m2, 2'b00}; end
        else e = arr;
      end
      default: e = arr;
    endcase
    return e;
  endfunction

  task automatic rd(input logic [2:0] m, input logic [7:0] ld, input logic [20:0] a,
                    input logic [31:0] msk, input logic to, input logic [7:0] arr,
                    input string tag, input int hold = 1);
    exp_q.push_back(model(m, ld, a, msk, to, arr));
    tag_q.push_back(tag);
    mode = m; last_data = ld; rd_addr = a; erase_mask = msk; timeout = to; array_data = arr;
    rd_stb = 1'b1;
    repeat (hold) @(negedge clk);
    -> smp;
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  always begin
    @(smp);
    check(dq, exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: dq=%02h expected completion", dq);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] held;
    logic [31:0] mk;
    mk = 32'h0000_0088;  // sectors 3 and 7 marked
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dq, 8'h00, "R1 reset");
    rd(3'd0, 8'h00, sa(1), mk, 1'b1, 8'hA5, "R2 idle");
    rd(3'd6, 8'h00, sa(3), mk, 1'b0, 8'h3C, "R2 code6");
    rd(3'd1, 8'h80, sa(2), mk, 1'b0, 8'hFF, "R3 R1 prog first");
    rd(3'd1, 8'h80, sa(9), mk, 1'b0, 8'hFF, "R5 prog toggle");
    rd(3'd1, 8'h00, sa(3), mk, 1'b0, 8'hFF, "R3 R6 prog bit7 0");
    rd(3'd2, 8'h00, sa(3), mk, 1'b0, 8'h00, "R4 R6 erase marked");
    rd(3'd2, 8'h00, sa(3), mk, 1'b0, 8'h00, "R6 erase marked again");
    rd(3'd2, 8'h00, sa(4), mk, 1'b0, 8'h00, "R6 erase unmarked");
    rd(3'd2, 8'h00, sa(7), mk, 1'b1, 8'h00, "R8 erase timeout");
    rd(3'd3, 8'h00, sa(5), mk, 1'b1, 8'h5A, "R7 susp unmarked");
    rd(3'd3, 8'h00, sa(7), mk, 1'b1, 8'h5A, "R7 susp marked");
    rd(3'd3, 8'h00, sa(3), mk, 1'b0, 8'h5A, "R7 susp marked again");
    rd(3'd4, 8'h7F, sa(3), mk, 1'b0, 8'hFF, "R3 R6 sprog marked");
    rd(3'd4, 8'h7F, sa(6), mk, 1'b1, 8'hFF, "R8 R9 sprog unmarked timeout");
    rd(3'd1, 8'hC3, sa(0), mk, 1'b1, 8'hFF, "R8 prog timeout");
    rd(3'd0, 8'h00, sa(7), mk, 1'b1, 8'h81, "R2 idle timeout");
    // R10: one read with the strobe held high for four cycles
    rd(3'd1, 8'h01, sa(2), mk, 1'b0, 8'hFF, "R10 held strobe", 4);
    held = dq;
    mode = 3'd2; last_data = 8'hFF; array_data = 8'h11; timeout = 1'b1;
    repeat (3) @(negedge clk);
    check(dq, held, "R10 no strobe");
    rd(3'd2, 8'h00, sa(7), mk, 1'b0, 8'h00, "R5 R10 after hold");
    rd(3'd2, 8'h00, sa(7), 32'h0, 1'b0, 8'h00, "R6 mask cleared");
    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule